// File: doc/BRIEF.md
# Transmit Serializer with Tristate Sequencing

This block drives a group of transmit lanes from a single fast serial clock. Every lane takes an 8-bit parallel word and sends it out one bit per clock, least significant bit first. The block creates its own load strobe. All lanes capture their next word together on that strobe, which comes once every 8 cycles in full-width mode and once every 4 cycles in half-width mode. A 4-bit write-enable word is captured on the same strobe and is shared by all lanes. Each enable bit covers two unit intervals of serial data.

Every lane also drives a tristate control output, and a 2-bit mode input per lane picks where it comes from. In enable mode, the tristate output carries the inverted enable bit for the current unit interval, so it stays aligned with the data. In raw mode, an asynchronous tristate input passes straight to the output through combinational logic. In gating mode, the driver stays on, and an enable bit of 0 replaces the data for its two unit intervals with the lane's idle level. Lane 1 is never gated.

A global active-low reset and a transmit reset for each lane force the data output to that lane's initial value and the tristate output to the shared initial tristate value. A lane leaving reset stays at those values until the next load strobe.

Top module: `tx_serdes_tri`

## Requirements
- R1: While rst_ni is low, and after it rises until the first word is loaded, every ser_o bit equals its init_data_i bit and every tri_o bit equals init_tri_i.
- R2: load_o is high in the first cycle after reset release and then exactly once every 8 cycles (width4_i=0) or every 4 cycles (width4_i=1); the word on data_i and wren_i is captured at the clock edge that ends a load_o cycle.
- R3: In the k-th cycle after a capture edge (k from 0), ser_o[l] equals bit 8*l+k of the captured data_i.
- R4: Mode 2'b00 (enable), full width: tri_o[l] equals the inverse of captured wren bit k/2 during unit interval k.
- R5: Half width: unit intervals 0 and 1 use wren bit 0, unit intervals 2 and 3 use wren bit 2, and wren bits 1 and 3 have no effect.
- R6: Mode 2'b01 (raw): outside reset, tri_o[l] follows tri_raw_i[l] combinationally, including changes in the middle of a word.
- R7: Mode 2'b10 or 2'b11 (gating): tri_o[l] is 0. An enable bit of 1 passes data and an enable bit of 0 drives init_data_i[l] on ser_o[l] for its unit intervals, with no inversion.
- R8: Lane 1 in gating mode always transmits its data bits, whatever the enable bits are.
- R9: While lane_rst_i[l] is high, lane l outputs init_data_i[l] and init_tri_i, and the other lanes are unaffected. After release, lane l keeps those values until the next capture edge and then transmits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| lane_rst_i | input | LANES | Per-lane transmit reset, active high |
| width4_i | input | 1 | 1 selects 4 bits per word, 0 selects 8 |
| lane_mode_i | input | 2*LANES | Tristate mode per lane: 00 enable, 01 raw, 1x gating |
| data_i | input | LANES*DATA_W | Parallel words; lane l uses bits [8l+7:8l] |
| wren_i | input | DATA_W/2 | Write-enable word, shared by all lanes |
| tri_raw_i | input | LANES | Asynchronous tristate inputs for raw mode |
| init_data_i | input | LANES | Idle and reset level of each data output |
| init_tri_i | input | 1 | Reset level of the tristate outputs |
| load_o | output | 1 | Load strobe; a word is captured at the end of this cycle |
| ser_o | output | LANES | Serial data outputs |
| tri_o | output | LANES | Tristate control outputs |

## Verification
The assertions assume that width4_i changes only while rst_ni is low. The load-period check and the shared unit-interval counter rely on that. They also assume that all inputs settle away from the rising clock edge. The bench changes the width only inside a reset pulse, drives every input at the falling edge, and moves the raw tristate inputs in the middle of a word to show that the output follows them without waiting for a load.

// File: rtl/tx_serdes_tri_pkg.sv
`timescale 1ns/1ps
package tx_serdes_tri_pkg;
  typedef enum logic [1:0] {
    TRI_WREN  = 2'b00,
    TRI_RAW   = 2'b01,
    TRI_GATE  = 2'b10,
    TRI_GATE2 = 2'b11
  } tri_mode_e;
endpackage

// File: rtl/tx_serdes_tri_seq.sv
`timescale 1ns/1ps
module tx_serdes_tri_seq #(
  parameter int DATA_W = 8,
  localparam int CW   = $clog2(DATA_W),
  localparam int EN_W = DATA_W / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            width4_i,
  input  logic [EN_W-1:0] wren_i,
  output logic            load_o,
  output logic            en_bit_o
);
  localparam logic [CW-1:0] LAST_F = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_H = CW'(DATA_W / 2 - 1);

  logic [CW-1:0]   cnt_q;
  logic [EN_W-1:0] en_q;
  logic [CW-1:0]   last;
  logic [CW-2:0]   half;
  logic [CW-2:0]   idx;

  assign last   = width4_i ? LAST_H : LAST_F;
  // counter resets to all-ones so the first cycle out of reset is a load
  assign load_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      en_q  <= '0;
    end else if (load_o) begin
      cnt_q <= '0;
      en_q  <= wren_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // one enable bit per pair of unit intervals; half width uses even bits only
  assign half     = cnt_q[CW-1:1];
  assign idx      = width4_i ? {half[CW-3:0], 1'b0} : half;
  assign en_bit_o = en_q[idx];
endmodule

// File: rtl/tx_serdes_tri_lane.sv
`timescale 1ns/1ps
module tx_serdes_tri_lane
  import tx_serdes_tri_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit GATE_OK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lane_rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        mode_i,
  input  logic              en_bit_i,
  input  logic              tri_raw_i,
  input  logic              init_data_i,
  input  logic              init_tri_i,
  output logic              ser_o,
  output logic              tri_o
);
  logic [DATA_W-1:0] sh_q;
  logic              valid_q;
  tri_mode_e         mode;

  assign mode = tri_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else if (lane_rst_i) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= data_i;
      valid_q <= 1'b1;
    end else begin
      sh_q    <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  always_comb begin
    ser_o = init_data_i;
    tri_o = init_tri_i;
    if (rst_ni && !lane_rst_i) begin
      unique case (mode)
        TRI_WREN: begin
          if (valid_q) begin
            ser_o = sh_q[0];
            tri_o = ~en_bit_i;
          end
        end
        TRI_RAW: begin
          tri_o = tri_raw_i;
          if (valid_q) ser_o = sh_q[0];
        end
        default: begin
          if (valid_q) begin
            tri_o = 1'b0;
            if (en_bit_i || !GATE_OK) ser_o = sh_q[0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tx_serdes_tri.sv
`timescale 1ns/1ps
module tx_serdes_tri #(
  parameter int LANES        = 6,
  parameter int DATA_W       = 8,
  parameter int UNGATED_LANE = 1,
  localparam int EN_W = DATA_W / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        lane_rst_i,
  input  logic                    width4_i,
  input  logic [2*LANES-1:0]      lane_mode_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  input  logic [EN_W-1:0]         wren_i,
  input  logic [LANES-1:0]        tri_raw_i,
  input  logic [LANES-1:0]        init_data_i,
  input  logic                    init_tri_i,
  output logic                    load_o,
  output logic [LANES-1:0]        ser_o,
  output logic [LANES-1:0]        tri_o
);
  logic load;
  logic en_bit;

  tx_serdes_tri_seq #(.DATA_W(DATA_W)) seq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .width4_i (width4_i),
    .wren_i   (wren_i),
    .load_o   (load),
    .en_bit_o (en_bit)
  );

  assign load_o = load;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tx_serdes_tri_lane #(
      .DATA_W  (DATA_W),
      .GATE_OK (l != UNGATED_LANE)
    ) lane_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lane_rst_i  (lane_rst_i[l]),
      .load_i      (load),
      .data_i      (data_i[l*DATA_W +: DATA_W]),
      .mode_i      (lane_mode_i[2*l +: 2]),
      .en_bit_i    (en_bit),
      .tri_raw_i   (tri_raw_i[l]),
      .init_data_i (init_data_i[l]),
      .init_tri_i  (init_tri_i),
      .ser_o       (ser_o[l]),
      .tri_o       (tri_o[l])
    );
  end
endmodule

// File: rtl/tx_serdes_tri_chk.sv
`timescale 1ns/1ps
module tx_serdes_tri_chk #(
  parameter int LANES  = 6,
  parameter int DATA_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [LANES-1:0]       lane_rst_i,
  input logic                   width4_i,
  input logic [2*LANES-1:0]     lane_mode_i,
  input logic [LANES-1:0]       tri_raw_i,
  input logic [LANES-1:0]       init_data_i,
  input logic                   init_tri_i,
  input logic                   load_o,
  input logic [LANES-1:0]       ser_o,
  input logic [LANES-1:0]       tri_o
);
  localparam int GW = $clog2(DATA_W) + 1;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2: strobe spacing matches the selected width
  p_load_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && seen_q) |-> (gap_q == GW'(width4_i ? DATA_W/2 - 1 : DATA_W - 1)));

  // R2: strobe is a single-cycle pulse
  p_load_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  // R1: outputs held at initial values during global reset
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_out_r1: assert (ser_o == init_data_i && tri_o == {LANES{init_tri_i}});
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R9
    p_lane_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_rst_i[l] |-> (ser_o[l] == init_data_i[l] && tri_o[l] == init_tri_i));
    // R6
    p_raw_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lane_rst_i[l] && lane_mode_i[2*l +: 2] == 2'b01) |-> (tri_o[l] == tri_raw_i[l]));
  end
endmodule

bind tx_serdes_tri tx_serdes_tri_chk #(.LANES(LANES), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/tx_serdes_tri_tb_top.sv
`timescale 1ns/1ps
module tx_serdes_tri_tb_top;
  localparam int L = 6;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [L-1:0]  lane_rst_i = '0;
  logic          width4_i = 1'b0;
  logic [2*L-1:0] lane_mode_i = '0;
  logic [L*W-1:0] data_i = '0;
  logic [3:0]    wren_i = '0;
  logic [L-1:0]  tri_raw_i = '0;
  logic [L-1:0]  init_data_i = 6'b101100;
  logic          init_tri_i = 1'b1;
  logic          load_o;
  logic [L-1:0]  ser_o, tri_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tx_serdes_tri dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lane_rst_i(lane_rst_i), .width4_i(width4_i),
    .lane_mode_i(lane_mode_i), .data_i(data_i), .wren_i(wren_i), .tri_raw_i(tri_raw_i),
    .init_data_i(init_data_i), .init_tri_i(init_tri_i), .load_o(load_o),
    .ser_o(ser_o), .tri_o(tri_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic w4);
    @(negedge clk);
    rst_ni = 1'b0;
    lane_rst_i = '0;
    width4_i = w4;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ser_o === init_data_i, "R1", "ser_o in reset", 32'(ser_o), 32'(init_data_i));
      chk(tri_o === {L{init_tri_i}}, "R1", "tri_o in reset", 32'(tri_o), 32'({L{init_tri_i}}));
    end
    rst_ni = 1'b1;
    #1;
    chk(load_o === 1'b1, "R2", "first load after reset", 32'(load_o), 32'd1);
  endtask

  // entered at a falling edge with load_o high; leaves at the next such edge
  task automatic run_word(input logic [L*W-1:0] d, input logic [3:0] we, input int rel_at);
    int n = width4_i ? 4 : 8;
    logic [L-1:0] masked = lane_rst_i;
    chk(load_o === 1'b1, "R2", "load at word start", 32'(load_o), 32'd1);
    data_i = d;
    wren_i = we;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == rel_at) lane_rst_i = '0;
      tri_raw_i = 6'(k * 37 + int'(d[5:0]));
      #1;
      for (int l = 0; l < L; l++) begin
        logic [1:0] m = lane_mode_i[2*l +: 2];
        logic eb = width4_i ? we[(k/2)*2] : we[k/2];
        logic bitv = d[l*W + k];
        logic es, et;
        string rs, rt;
        if (masked[l]) begin
          es = init_data_i[l]; et = init_tri_i; rs = "R9"; rt = "R9";
        end else if (m == 2'b00) begin
          es = bitv; et = ~eb; rs = "R3"; rt = width4_i ? "R5" : "R4";
        end else if (m == 2'b01) begin
          es = bitv; et = tri_raw_i[l]; rs = "R3"; rt = "R6";
        end else begin
          es = (eb || l == 1) ? bitv : init_data_i[l];
          et = 1'b0; rs = (l == 1) ? "R8" : "R7"; rt = "R7";
        end
        chk(ser_o[l] === es, rs, $sformatf("ser_o[%0d] ui %0d", l, k), 32'(ser_o[l]), 32'(es));
        chk(tri_o[l] === et, rt, $sformatf("tri_o[%0d] ui %0d", l, k), 32'(tri_o[l]), 32'(et));
      end
      chk(load_o === (k == n - 1), "R2", $sformatf("load_o ui %0d", k), 32'(load_o), 32'(k == n - 1));
    end
  endtask

  // R3 R4: enable mode, full width
  task automatic t_wren8();
    lane_mode_i = '0;
    do_reset(1'b0);
    run_word(48'h5A3C_F00F_8127, 4'b1010, -1);
    run_word(48'hA5C3_0FF0_7E18, 4'b0110, -1);
    run_word(48'hFFFF_0000_AAAA, 4'b1111, -1);
  endtask

  // R5: half width, odd enable bits ignored
  task automatic t_wren4();
    lane_mode_i = '0;
    do_reset(1'b1);
    run_word(48'h1234_5678_9ABC, 4'b1010, -1);
    run_word(48'hFEDC_BA98_7654, 4'b0101, -1);
    run_word(48'h0F0F_F0F0_3C3C, 4'b1011, -1);
  endtask

  // R6: raw tristate passthrough
  task automatic t_raw();
    lane_mode_i = {L{2'b01}};
    do_reset(1'b0);
    run_word(48'hC0FF_EE12_3456, 4'b0000, -1);
    run_word(48'h0011_2233_4455, 4'b1111, -1);
  endtask

  // R7 R8: gating, both widths, lane 1 exempt
  task automatic t_gate();
    lane_mode_i = {2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11};
    do_reset(1'b0);
    run_word(48'hFFFF_FFFF_FFFF, 4'b0101, -1);
    run_word(48'h0000_0000_0000, 4'b1010, -1);
    do_reset(1'b1);
    run_word(48'hFFFF_FFFF_FFFF, 4'b0100, -1);
    run_word(48'h5555_5555_5555, 4'b0001, -1);
  endtask

  // mixed modes per lane, different idle levels
  task automatic t_mixed();
    init_data_i = 6'b010011;
    init_tri_i  = 1'b0;
    lane_mode_i = {2'b10, 2'b00, 2'b11, 2'b01, 2'b10, 2'b00};
    do_reset(1'b0);
    run_word(48'h9876_5432_10FE, 4'b0110, -1);
    run_word(48'hF00D_FACE_B00C, 4'b1001, -1);
  endtask

  // R9: lane reset while held, mid-word release, resume at next load
  task automatic t_lane_rst();
    init_data_i = 6'b110101;
    init_tri_i  = 1'b1;
    lane_mode_i = '0;
    do_reset(1'b0);
    run_word(48'h1111_2222_3333, 4'b1100, -1);
    lane_rst_i = 6'b000100;
    #1;
    chk(ser_o[2] === init_data_i[2], "R9", "ser_o[2] on assert", 32'(ser_o[2]), 32'(init_data_i[2]));
    run_word(48'hFFFF_FFFF_FFFF, 4'b0000, -1);
    lane_rst_i = 6'b100100;
    run_word(48'h0000_0000_0000, 4'b1111, 3);
    run_word(48'hFFFF_FFFF_FFFF, 4'b0000, -1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_wren8();
    t_wren4();
    t_raw();
    t_gate();
    t_mixed();
    t_lane_rst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule